// File: doc/BRIEF.md
# DDR Command Decoder and Bank Tracker

This block watches the control pins of a double-data-rate SDRAM command bus (chip select, row strobe, column strobe, write enable, clock enable, bank select and the auto-precharge address bit) and turns every clock's sample into one decoded command. It follows the idle or open state of each of the four banks and keeps per-bank and device-wide down-counters. With these it decides whether a command came too early or went to a bank in the wrong state. It suits a memory-bus monitor next to a controller or a behavioural memory front end.

Each command sampled on a rising edge shows up on the outputs one clock later: the command code, the bank number, the auto-precharge flag and a one-cycle violation strobe. A command that breaks a rule is still reported, but it does not change any bank state or restart any counter. Every timing limit is a parameter. The defaults are the clock counts of a 250 MHz grade part.

Top module: `ddr_cmd_tracker`

## Requirements
- R1: With `csN` high the cycle decodes as deselect (code 0). With `csN` low and `rasN`, `casN`, `weN` all high it decodes as NOP (code 1). Neither one ever raises `violation`.
- R2: With `csN` low the pins `{rasN,casN,weN}` decode as follows: 011 activate (2), 101 read (3), 100 write (4), 010 precharge (5, `apBit` low) or precharge-all (6, `apBit` high), 110 burst stop (11). Each code, with `bankOut` equal to `bankSel`, appears one clock after the sampling edge.
- R3: 000 with `cke` high is a mode-register write. It gives code 7 when `bankSel[0]`=0 and code 8 when `bankSel[0]`=1.
- R4: 001 gives auto refresh (9) when `cke` is high and self-refresh entry (10) when `cke` is low.
- R5: `autoPre` repeats `apBit` for read and write and is 0 for every other command.
- R6: When `cke` was low at the previous sampling edge, a command with `csN` low decodes as NOP (1) and has no effect on bank state. The state after reset counts as `cke` low.
- R7: A read or write to an idle bank, or an activate to an open bank, raises `violation` and leaves the bank state unchanged.
- R8: A read or write to an open bank is flagged if it comes less than T_RCDRD (4) clocks after that bank's activate for a read, or T_RCDWR (2) clocks for a write.
- R9: A precharge to an open bank is flagged if it comes less than T_RAS (9) clocks after that bank's activate or less than T_WR (3) clocks after its last write. A precharge to an idle bank is accepted and has no effect.
- R10: An activate is flagged if it comes less than T_RP (4) clocks after that bank closed, or less than T_RRD (3) clocks after any activate.
- R11: A mode-register write needs all banks idle with T_RP elapsed. Any command other than NOP or deselect is flagged until T_MRD (2) clocks after it.
- R12: Auto refresh and self-refresh entry are flagged unless all banks are idle with T_RP elapsed.
- R13: A read or write with `apBit` high closes its bank on its own once both T_RAS and T_WR have elapsed, and T_RP starts then. Until the bank has closed and T_RP has elapsed, reads, writes and activates to that bank are flagged.
- R14: Precharge-all closes every open bank. It is flagged, and closes none, if any open bank still has T_RAS or T_WR pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| bankSel | input | 2 | Bank select |
| apBit | input | 1 | Auto-precharge / all-banks address bit |
| cmdCode | output | 4 | Decoded command code |
| bankOut | output | 2 | Bank of the decoded command |
| autoPre | output | 1 | Auto-precharge requested by a read or write |
| violation | output | 1 | One-cycle strobe for a rule breach |

## Verification
The self-closing bank is the hardest state to reach. A write with auto-precharge has to arrive after its activate-to-write delay and must then wait out both the row-active and write-recovery counters, while the precharge period only starts once the bank has closed. The bench reaches it with a directed clock-exact sequence. It probes the bank with a read while the close is pending, then with activates one clock before and exactly at the earliest legal edge. A similar sequence lines up a write late in the row-active window so that write recovery, not row-active time, decides when precharge becomes legal.

// File: rtl/ddr_cmd_pkg.sv
package ddr_cmd_pkg;

  parameter int unsigned BANK_W = 2;

  typedef enum logic [3:0] {
    CMD_DESEL = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_ACT   = 4'd2,
    CMD_RD    = 4'd3,
    CMD_WR    = 4'd4,
    CMD_PRE   = 4'd5,
    CMD_PREA  = 4'd6,
    CMD_MRS   = 4'd7,
    CMD_EMRS  = 4'd8,
    CMD_REF   = 4'd9,
    CMD_SREF  = 4'd10,
    CMD_BST   = 4'd11
  } ddrCmd_e;

  // Accepted (legal) commands only; control -> datapath.
  typedef struct packed {
    logic              act;
    logic              rd;
    logic              wr;
    logic              pre;
    logic              preAll;
    logic              modeWr;
    logic              ap;
    logic [BANK_W-1:0] bank;
  } bankStrobe_t;

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ddr_bank_slot.sv
module ddr_bank_slot
  import ddr_cmd_pkg::*;
#(
  parameter int IDX     = 0,
  parameter int CW      = 4,
  parameter int T_RCDRD = 4,
  parameter int T_RCDWR = 2,
  parameter int T_RAS   = 9,
  parameter int T_RP    = 4,
  parameter int T_WR    = 3
) (
  input  logic        clk,
  input  logic        rstN,
  input  bankStrobe_t strb,
  output logic        isOpen,
  output logic        isPend,
  output logic        rdOk,
  output logic        wrOk,
  output logic        preOk,
  output logic        idleOk
);

  logic [CW-1:0] rcdRdCnt, rcdWrCnt, rasCnt, rpCnt, wrCnt;
  logic          openQ, pendQ;
  logic          selMe, closeReq, autoClose;

  assign selMe     = (strb.bank == BANK_W'(IDX));
  assign closeReq  = openQ && !pendQ && ((strb.pre && selMe) || strb.preAll);
  assign autoClose = pendQ && (rasCnt == '0) && (wrCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openQ    <= 1'b0;
      pendQ    <= 1'b0;
      rcdRdCnt <= '0;
      rcdWrCnt <= '0;
      rasCnt   <= '0;
      rpCnt    <= '0;
      wrCnt    <= '0;
    end else begin
      if (rcdRdCnt != '0) rcdRdCnt <= rcdRdCnt - 1'b1;
      if (rcdWrCnt != '0) rcdWrCnt <= rcdWrCnt - 1'b1;
      if (rasCnt   != '0) rasCnt   <= rasCnt - 1'b1;
      if (rpCnt    != '0) rpCnt    <= rpCnt - 1'b1;
      if (wrCnt    != '0) wrCnt    <= wrCnt - 1'b1;

      if (strb.act && selMe) begin
        openQ    <= 1'b1;
        rcdRdCnt <= CW'(T_RCDRD - 1);
        rcdWrCnt <= CW'(T_RCDWR - 1);
        rasCnt   <= CW'(T_RAS - 1);
      end
      if (strb.wr && selMe) begin
        wrCnt <= CW'(T_WR - 1);
        if (strb.ap) pendQ <= 1'b1;
      end
      if (strb.rd && selMe && strb.ap) pendQ <= 1'b1;
      if (closeReq || autoClose) begin
        openQ <= 1'b0;
        pendQ <= 1'b0;
        rpCnt <= CW'(T_RP - 1);
      end
    end
  end

  assign isOpen = openQ;
  assign isPend = pendQ;
  assign rdOk   = (rcdRdCnt == '0);
  assign wrOk   = (rcdWrCnt == '0);
  assign preOk  = (rasCnt == '0) && (wrCnt == '0);
  assign idleOk = !openQ && (rpCnt == '0);

  // R7
  col_open_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.rd || strb.wr) && selMe) |-> (openQ && !pendQ));

  // R8
  rd_after_act_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rd && selMe) |-> (rcdRdCnt == '0));

  // R10
  act_after_pre_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.act && selMe) |-> (!openQ && rpCnt == '0));

  // R11
  mode_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.modeWr |-> (!openQ && rpCnt == '0));

endmodule

// File: rtl/ddr_bank_timer.sv
module ddr_bank_timer
  import ddr_cmd_pkg::*;
#(
  parameter int NB      = 4,
  parameter int CW      = 4,
  parameter int T_RCDRD = 4,
  parameter int T_RCDWR = 2,
  parameter int T_RAS   = 9,
  parameter int T_RP    = 4,
  parameter int T_RRD   = 3,
  parameter int T_WR    = 3,
  parameter int T_MRD   = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  bankStrobe_t   strb,
  output logic [NB-1:0] openMask,
  output logic [NB-1:0] pendMask,
  output logic [NB-1:0] rdOkMask,
  output logic [NB-1:0] wrOkMask,
  output logic [NB-1:0] preOkMask,
  output logic [NB-1:0] idleOkMask,
  output logic          rrdOk,
  output logic          mrdOk
);

  logic [CW-1:0] rrdCnt, mrdCnt;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    ddr_bank_slot #(
      .IDX(g), .CW(CW), .T_RCDRD(T_RCDRD), .T_RCDWR(T_RCDWR),
      .T_RAS(T_RAS), .T_RP(T_RP), .T_WR(T_WR)
    ) i_slot (
      .clk   (clk),
      .rstN  (rstN),
      .strb  (strb),
      .isOpen(openMask[g]),
      .isPend(pendMask[g]),
      .rdOk  (rdOkMask[g]),
      .wrOk  (wrOkMask[g]),
      .preOk (preOkMask[g]),
      .idleOk(idleOkMask[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrdCnt <= '0;
      mrdCnt <= '0;
    end else begin
      if (strb.act)           rrdCnt <= CW'(T_RRD - 1);
      else if (rrdCnt != '0)  rrdCnt <= rrdCnt - 1'b1;
      if (strb.modeWr)        mrdCnt <= CW'(T_MRD - 1);
      else if (mrdCnt != '0)  mrdCnt <= mrdCnt - 1'b1;
    end
  end

  assign rrdOk = (rrdCnt == '0);
  assign mrdOk = (mrdCnt == '0);

  // R10
  act_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.act |-> (rrdCnt == '0));

  // R11
  mode_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mrdCnt != '0) |-> !(strb.act || strb.rd || strb.wr || strb.pre ||
                         strb.preAll || strb.modeWr));

endmodule

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
  import ddr_cmd_pkg::*;
#(
  parameter int NB = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              cke,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              apBit,
  input  logic [NB-1:0]     openMask,
  input  logic [NB-1:0]     pendMask,
  input  logic [NB-1:0]     rdOkMask,
  input  logic [NB-1:0]     wrOkMask,
  input  logic [NB-1:0]     preOkMask,
  input  logic [NB-1:0]     idleOkMask,
  input  logic              rrdOk,
  input  logic              mrdOk,
  output bankStrobe_t       strb,
  output ddrCmd_e           cmdQ,
  output logic [BANK_W-1:0] bankQ,
  output logic              apQ,
  output logic              violQ
);

  logic    ckePrev;
  ddrCmd_e cmdD;
  logic    violD;
  logic    anyCmd;
  logic    bankOpen, bankPend;

  assign bankOpen = openMask[bankSel];
  assign bankPend = pendMask[bankSel];

  always_comb begin
    cmdD = CMD_NOP;
    if (csN) begin
      cmdD = CMD_DESEL;
    end else if (ckePrev) begin
      case ({rasN, casN, weN})
        3'b011:  cmdD = CMD_ACT;
        3'b010:  cmdD = apBit ? CMD_PREA : CMD_PRE;
        3'b101:  cmdD = CMD_RD;
        3'b100:  cmdD = CMD_WR;
        3'b000:  cmdD = cke ? (bankSel[0] ? CMD_EMRS : CMD_MRS) : CMD_NOP;
        3'b001:  cmdD = cke ? CMD_REF : CMD_SREF;
        3'b110:  cmdD = CMD_BST;
        default: cmdD = CMD_NOP;
      endcase
    end
  end

  assign anyCmd = (cmdD != CMD_DESEL) && (cmdD != CMD_NOP);

  always_comb begin
    violD = anyCmd && !mrdOk;
    case (cmdD)
      CMD_ACT:  if (bankOpen || !idleOkMask[bankSel] || !rrdOk) violD = 1'b1;
      CMD_RD:   if (!bankOpen || bankPend || !rdOkMask[bankSel]) violD = 1'b1;
      CMD_WR:   if (!bankOpen || bankPend || !wrOkMask[bankSel]) violD = 1'b1;
      CMD_PRE:  if (bankOpen && !bankPend && !preOkMask[bankSel]) violD = 1'b1;
      CMD_PREA: if (|(openMask & ~pendMask & ~preOkMask)) violD = 1'b1;
      CMD_MRS, CMD_EMRS, CMD_REF, CMD_SREF:
                if (!(&idleOkMask)) violD = 1'b1;
      default:  ;
    endcase
  end

  always_comb begin
    strb        = '0;
    strb.bank   = bankSel;
    strb.ap     = apBit;
    if (!violD) begin
      strb.act    = (cmdD == CMD_ACT);
      strb.rd     = (cmdD == CMD_RD);
      strb.wr     = (cmdD == CMD_WR);
      strb.pre    = (cmdD == CMD_PRE);
      strb.preAll = (cmdD == CMD_PREA);
      strb.modeWr = (cmdD == CMD_MRS) || (cmdD == CMD_EMRS);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ckePrev <= 1'b0;
      cmdQ    <= CMD_DESEL;
      bankQ   <= '0;
      apQ     <= 1'b0;
      violQ   <= 1'b0;
    end else begin
      ckePrev <= cke;
      cmdQ    <= cmdD;
      bankQ   <= bankSel;
      apQ     <= apBit && ((cmdD == CMD_RD) || (cmdD == CMD_WR));
      violQ   <= violD;
    end
  end

  // R1
  quiet_no_viol_chk: assert property (@(posedge clk) disable iff (!rstN)
    violQ |-> !(cmdQ == CMD_DESEL || cmdQ == CMD_NOP));

  // R5
  ap_col_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    apQ |-> (cmdQ == CMD_RD || cmdQ == CMD_WR));

  // R6
  cke_wake_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!ckePrev && !csN) |=> (cmdQ == CMD_NOP && !violQ));

endmodule

// File: rtl/ddr_cmd_tracker.sv
module ddr_cmd_tracker
  import ddr_cmd_pkg::*;
#(
  parameter int T_RCDRD = 4,
  parameter int T_RCDWR = 2,
  parameter int T_RAS   = 9,
  parameter int T_RP    = 4,
  parameter int T_RRD   = 3,
  parameter int T_WR    = 3,
  parameter int T_MRD   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              rasN,
  input  logic              casN,
  input  logic              weN,
  input  logic              cke,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              apBit,
  output logic [3:0]        cmdCode,
  output logic [BANK_W-1:0] bankOut,
  output logic              autoPre,
  output logic              violation
);

  localparam int NB    = 1 << BANK_W;
  localparam int T_MAX = maxInt(maxInt(maxInt(T_RCDRD, T_RCDWR), maxInt(T_RAS, T_RP)),
                                maxInt(maxInt(T_RRD, T_WR), T_MRD));
  localparam int CW    = $clog2(T_MAX + 1);

  bankStrobe_t   strb;
  ddrCmd_e       cmdQ;
  logic [NB-1:0] openMask, pendMask, rdOkMask, wrOkMask, preOkMask, idleOkMask;
  logic          rrdOk, mrdOk;

  ddr_cmd_decode #(.NB(NB)) i_decode (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .bankSel(bankSel), .apBit(apBit),
    .openMask(openMask), .pendMask(pendMask), .rdOkMask(rdOkMask),
    .wrOkMask(wrOkMask), .preOkMask(preOkMask), .idleOkMask(idleOkMask),
    .rrdOk(rrdOk), .mrdOk(mrdOk), .strb(strb),
    .cmdQ(cmdQ), .bankQ(bankOut), .apQ(autoPre), .violQ(violation)
  );

  ddr_bank_timer #(
    .NB(NB), .CW(CW), .T_RCDRD(T_RCDRD), .T_RCDWR(T_RCDWR), .T_RAS(T_RAS),
    .T_RP(T_RP), .T_RRD(T_RRD), .T_WR(T_WR), .T_MRD(T_MRD)
  ) i_timer (
    .clk(clk), .rstN(rstN), .strb(strb),
    .openMask(openMask), .pendMask(pendMask), .rdOkMask(rdOkMask),
    .wrOkMask(wrOkMask), .preOkMask(preOkMask), .idleOkMask(idleOkMask),
    .rrdOk(rrdOk), .mrdOk(mrdOk)
  );

  assign cmdCode = cmdQ;

endmodule

// File: tb/test_ddr_cmd_tracker.sv
module test_ddr_cmd_tracker;

  localparam int CLK_PERIOD = 10;

  localparam int C_DESEL = 0, C_NOP = 1, C_ACT = 2, C_RD = 3, C_WR = 4,
                 C_PRE = 5, C_PREA = 6, C_MRS = 7, C_EMRS = 8, C_REF = 9,
                 C_SREF = 10, C_BST = 11;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1, rasN = 1'b1, casN = 1'b1, weN = 1'b1, cke = 1'b1;
  logic [1:0] bankSel = 2'd0;
  logic       apBit = 1'b0;
  logic [3:0] cmdCode;
  logic [1:0] bankOut;
  logic       autoPre, violation;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_cmd_tracker i_ddr_cmd_tracker (
    .clk(clk), .rstN(rstN), .csN(csN), .rasN(rasN), .casN(casN), .weN(weN),
    .cke(cke), .bankSel(bankSel), .apBit(apBit),
    .cmdCode(cmdCode), .bankOut(bankOut), .autoPre(autoPre), .violation(violation)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One command per rising edge; outputs read 1 time unit after that edge.
  task automatic send(input int c, input int b, input bit ap);
    @(negedge clk);
    csN = 1'b0; cke = 1'b1; bankSel = 2'(b); apBit = ap;
    {rasN, casN, weN} = 3'b111;
    case (c)
      C_DESEL: csN = 1'b1;
      C_ACT:   {rasN, casN, weN} = 3'b011;
      C_RD:    {rasN, casN, weN} = 3'b101;
      C_WR:    {rasN, casN, weN} = 3'b100;
      C_PRE:   begin {rasN, casN, weN} = 3'b010; apBit = 1'b0; end
      C_PREA:  begin {rasN, casN, weN} = 3'b010; apBit = 1'b1; end
      C_MRS:   begin {rasN, casN, weN} = 3'b000; bankSel = 2'd0; end
      C_EMRS:  begin {rasN, casN, weN} = 3'b000; bankSel = 2'd1; end
      C_REF:   {rasN, casN, weN} = 3'b001;
      C_SREF:  begin {rasN, casN, weN} = 3'b001; cke = 1'b0; end
      C_BST:   {rasN, casN, weN} = 3'b110;
      default: ;
    endcase
    @(posedge clk);
    #1;
  endtask

  task automatic step(input string tag, input int c, input int b, input bit ap,
                      input int expC, input int expV);
    send(c, b, ap);
    check({tag, " code"}, int'(cmdCode), expC);
    check({tag, " violation"}, int'(violation), expV);
  endtask

  task automatic nops(input int n);
    for (int i = 0; i < n; i++) send(C_NOP, 0, 1'b0);
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset code", int'(cmdCode), C_DESEL);
    check("R1 reset violation", int'(violation), 0);
    check("R5 reset autoPre", int'(autoPre), 0);
    @(negedge clk);
    rstN = 1'b1;
    nops(2);
  endtask

  task automatic t_decode;
    step("R1 deselect", C_DESEL, 0, 1'b0, C_DESEL, 0);
    step("R1 nop", C_NOP, 0, 1'b0, C_NOP, 0);
    step("R2 burst stop", C_BST, 0, 1'b0, C_BST, 0);
    step("R3 mode reg", C_MRS, 0, 1'b0, C_MRS, 0);
    nops(1);
    step("R3 ext mode reg", C_EMRS, 1, 1'b0, C_EMRS, 0);
    nops(1);
    step("R4 refresh", C_REF, 0, 1'b0, C_REF, 0);
    // R11: command one clock after a mode write is early, two clocks is fine
    step("R11 mode spacing early", C_MRS, 0, 1'b0, C_MRS, 0);
    step("R11 burst stop early", C_BST, 0, 1'b0, C_BST, 1);
    step("R11 burst stop ok", C_BST, 0, 1'b0, C_BST, 0);
  endtask

  task automatic t_bank_timing;
    step("R2 act b0", C_ACT, 0, 1'b0, C_ACT, 0);
    step("R8 write early", C_WR, 0, 1'b0, C_WR, 1);
    step("R8 write ok", C_WR, 0, 1'b0, C_WR, 0);
    step("R8 read early", C_RD, 0, 1'b0, C_RD, 1);
    step("R8 read ok", C_RD, 0, 1'b0, C_RD, 0);
    check("R5 read no ap", int'(autoPre), 0);
    step("R7 act open bank", C_ACT, 0, 1'b0, C_ACT, 1);
    step("R9 pre before tras", C_PRE, 0, 1'b0, C_PRE, 1);
    nops(1);
    step("R9 pre one early", C_PRE, 0, 1'b0, C_PRE, 1);
    step("R9 pre at tras", C_PRE, 0, 1'b0, C_PRE, 0);
    step("R7 read idle bank", C_RD, 0, 1'b0, C_RD, 1);
    step("R9 pre idle bank", C_PRE, 0, 1'b0, C_PRE, 0);
    step("R10 act before trp", C_ACT, 0, 1'b0, C_ACT, 1);
    step("R10 act at trp", C_ACT, 0, 1'b0, C_ACT, 0);
    nops(8);
    step("R9 late write", C_WR, 0, 1'b0, C_WR, 0);
    step("R9 pre in twr", C_PRE, 0, 1'b0, C_PRE, 1);
    step("R9 pre twr one early", C_PRE, 0, 1'b0, C_PRE, 1);
    step("R9 pre after twr", C_PRE, 0, 1'b0, C_PRE, 0);
    nops(4);
  endtask

  task automatic t_multi_bank;
    step("R10 act b1", C_ACT, 1, 1'b0, C_ACT, 0);
    step("R10 act b2 rrd", C_ACT, 2, 1'b0, C_ACT, 1);
    step("R10 act b2 rrd again", C_ACT, 2, 1'b0, C_ACT, 1);
    step("R10 act b2 ok", C_ACT, 2, 1'b0, C_ACT, 0);
    check("R2 bank number", int'(bankOut), 2);
    step("R14 prea early", C_PREA, 0, 1'b1, C_PREA, 1);
    check("R5 prea no ap", int'(autoPre), 0);
    step("R12 refresh open", C_REF, 0, 1'b0, C_REF, 1);
    nops(6);
    step("R14 prea ok", C_PREA, 0, 1'b1, C_PREA, 0);
    step("R14 read closed b1", C_RD, 1, 1'b0, C_RD, 1);
    step("R12 refresh in trp", C_REF, 0, 1'b0, C_REF, 1);
    nops(1);
    step("R12 refresh ok", C_REF, 0, 1'b0, C_REF, 0);
  endtask

  task automatic t_auto_pre;
    step("R13 act b3", C_ACT, 3, 1'b0, C_ACT, 0);
    nops(1);
    step("R13 write ap", C_WR, 3, 1'b1, C_WR, 0);
    check("R5 write ap", int'(autoPre), 1);
    step("R13 read pending", C_RD, 3, 1'b0, C_RD, 1);
    nops(8);
    step("R13 act before trp", C_ACT, 3, 1'b0, C_ACT, 1);
    step("R13 act after close", C_ACT, 3, 1'b0, C_ACT, 0);
    nops(8);
    step("R14 prea b3", C_PREA, 0, 1'b1, C_PREA, 0);
    nops(3);
  endtask

  task automatic t_cke;
    step("R4 self refresh", C_SREF, 0, 1'b0, C_SREF, 0);
    step("R6 act after cke low", C_ACT, 0, 1'b0, C_NOP, 0);
    step("R6 act b0 still idle", C_ACT, 0, 1'b1, C_ACT, 0);
    check("R5 act no ap", int'(autoPre), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_decode();
    t_bank_timing();
    t_multi_bank();
    t_auto_pre();
    t_cke();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule